// File: doc/BRIEF.md
# Low-Region I/O Register Decoder

This block sits on a simple single-cycle read/write bus and answers every access that falls in the low, memory-mapped I/O part of the address space. It offers four read-only words at the very bottom of memory: two fixed constants and live views of the running thread's program counter and status word. Writes to these four words do nothing. Any address at or above 512 MB is not answered here. For such an address the block raises a RAM-select strobe so that the memory path can take the access.

Further up in the I/O range sits a polled byte port with four words: transmit data, transmit status, receive data and receive status. The transmit side holds one byte and offers it on a valid/ready stream. The receive side holds one byte, which it takes from a valid/ready stream. Software polls the status words, writes bytes out and reads bytes in. Serial bit timing belongs to whatever is attached to the two streams.

Read data is combinational and valid in the same cycle as the access strobe. Bits 1:0 of the address are not decoded. The block has an asynchronous active-low reset, which it releases synchronously inside the block two clock edges after `rst_n` rises.

Top module: `lowmem_io_decoder`

## Requirements
- R1: A read of address 0x0 returns 0x00000000, and a read of address 0x4 returns 0x80000000.
- R2: A read of address 0x8 returns `thread_pc`, and a read of address 0xC returns `thread_psw`, as they are in the same cycle.
- R3: Writes to addresses 0x0, 0x4, 0x8 and 0xC change no read value and start no transmission.
- R4: A write to 0x08000000 while the transmit slot is empty raises `tx_valid` on the next clock edge, with bits 7:0 of the write data on `tx_data`. Both stay unchanged until a cycle in which `tx_ready` is high empties the slot.
- R5: A read of 0x08000004 returns 1 in bit 0 when the transmit slot is empty and 0 when it is full. All its other bits read 0. A write to 0x08000000 while the slot is full is dropped.
- R6: While the receive slot is empty, `rx_ready` is high, and a cycle with `rx_valid` high loads `rx_data` into the slot. While the slot is full, `rx_ready` is low. A read of 0x0800000C returns 1 in bit 0 when the slot is full and 0 otherwise, with all other bits 0.
- R7: A read of 0x08000008 returns the held byte in bits 7:0, with all higher bits 0, and empties the slot on the same clock edge. When the slot is empty, the read returns 0.
- R8: Reads of unmapped I/O addresses below 0x20000000 return 0. For any access at or above 0x20000000, `ram_sel` is high and `bus_rdata` is 0. `ram_sel` is low when `bus_sel` is low or the address is below 0x20000000.
- R9: After reset, the transmit slot and the receive slot are both empty: `tx_valid` is low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ram_sel | output | 1 | Access targets the RAM region |
| thread_pc | input | 32 | Program counter of the active thread |
| thread_psw | input | 32 | Status word of the active thread |
| tx_data | output | 8 | Byte offered for transmission |
| tx_valid | output | 1 | Transmit slot holds a byte |
| tx_ready | input | 1 | Sink takes the offered byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receive slot can take a byte |

## Verification
The properties are checked against the internally synchronised reset. They assume that no access or stream traffic occurs in the two cycles while that reset is still being released, and that bus inputs are stable across each clock edge. The bench holds every input idle until several cycles after `rst_n` rises and changes inputs only on falling edges. The drop and hold properties assume that the transmit sink keeps `tx_ready` low whenever it must not take a byte. The bench raises `tx_ready` only for the single cycle in which it wants to empty the slot.

// File: rtl/lmio_pkg.sv
package lmio_pkg;

  // One select line per decoded target
  typedef struct packed {
    logic zero;
    logic neg;
    logic pc;
    logic psw;
    logic txbuf;
    logic txstat;
    logic rxbuf;
    logic rxstat;
    logic ram;
  } lmio_hit_t;

  localparam logic [31:0] LMIO_UART_BASE = 32'h0800_0000;
  localparam logic [31:0] LMIO_RAM_BASE  = 32'h2000_0000;

endpackage

// File: rtl/lmio_rst_sync.sv
module lmio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/lmio_addr_decode.sv
module lmio_addr_decode
  import lmio_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]   UART_BASE = ADDR_W'(LMIO_UART_BASE),
  parameter logic [ADDR_W-1:0]   RAM_BASE  = ADDR_W'(LMIO_RAM_BASE)
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output lmio_hit_t         hit
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              in_ram;
  logic [1:0]        unused_lsb;

  assign word_idx   = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];
  assign in_ram     = (addr >= RAM_BASE);

  function automatic logic at(input logic [WORD_W-1:0] w,
                              input logic [ADDR_W-1:0] byte_addr);
    return w == byte_addr[ADDR_W-1:2];
  endfunction

  always_comb begin
    hit        = '0;
    hit.ram    = sel && in_ram;
    hit.zero   = sel && at(word_idx, ADDR_W'(0));
    hit.neg    = sel && at(word_idx, ADDR_W'(4));
    hit.pc     = sel && at(word_idx, ADDR_W'(8));
    hit.psw    = sel && at(word_idx, ADDR_W'(12));
    hit.txbuf  = sel && at(word_idx, UART_BASE);
    hit.txstat = sel && at(word_idx, UART_BASE + ADDR_W'(4));
    hit.rxbuf  = sel && at(word_idx, UART_BASE + ADDR_W'(8));
    hit.rxstat = sel && at(word_idx, UART_BASE + ADDR_W'(12));
  end
endmodule

// File: rtl/lmio_tx_slot.sv
module lmio_tx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic              full_q, full_d;
  logic [BYTE_W-1:0] byte_q;
  logic              load_en;

  assign load_en = wr_req && !full_q;

  always_comb begin
    full_d = full_q;
    if (load_en)                full_d = 1'b1;
    else if (full_q && tx_ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (load_en) byte_q <= wr_byte;
  end

  assign tx_valid = full_q;
  assign tx_data  = byte_q;
endmodule

// File: rtl/lmio_rx_slot.sv
module lmio_rx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              pop_req,
  output logic              held,
  output logic [BYTE_W-1:0] held_byte
);
  logic              full_q, full_d;
  logic [BYTE_W-1:0] byte_q;
  logic              take_en;

  assign take_en = rx_valid && !full_q;

  always_comb begin
    full_d = full_q;
    if (take_en)                full_d = 1'b1;
    else if (pop_req && full_q) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (take_en) byte_q <= rx_data;
  end

  assign rx_ready  = !full_q;
  assign held      = full_q;
  assign held_byte = full_q ? byte_q : '0;
endmodule

// File: rtl/lowmem_io_decoder.sv
module lowmem_io_decoder
  import lmio_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] UART_BASE = ADDR_W'(LMIO_UART_BASE),
  parameter logic [ADDR_W-1:0] RAM_BASE  = ADDR_W'(LMIO_RAM_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_sel,
  input  logic [DATA_W-1:0] thread_pc,
  input  logic [DATA_W-1:0] thread_psw,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam logic [DATA_W-1:0] NEG_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic              rst_n_sync;
  lmio_hit_t         hit;
  logic              rd_en, wr_en;
  logic              rx_held;
  logic [BYTE_W-1:0] rx_byte;
  logic [DATA_W-BYTE_W-1:0] unused_wdata_hi;

  assign rd_en           = bus_sel && !bus_we;
  assign wr_en           = bus_sel &&  bus_we;
  assign unused_wdata_hi = bus_wdata[DATA_W-1:BYTE_W];

  lmio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lmio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .UART_BASE (UART_BASE),
    .RAM_BASE  (RAM_BASE)
  ) u_dec (
    .sel  (bus_sel),
    .addr (bus_addr),
    .hit  (hit)
  );

  lmio_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_req   (wr_en && hit.txbuf),
    .wr_byte  (bus_wdata[BYTE_W-1:0]),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready)
  );

  lmio_rx_slot #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .pop_req   (rd_en && hit.rxbuf),
    .held      (rx_held),
    .held_byte (rx_byte)
  );

  // Read mux; constant words ignore writes since nothing stores them
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit.neg)         bus_rdata = NEG_WORD;
      else if (hit.pc)     bus_rdata = thread_pc;
      else if (hit.psw)    bus_rdata = thread_psw;
      else if (hit.txstat) bus_rdata = DATA_W'(!tx_valid);
      else if (hit.rxbuf)  bus_rdata = DATA_W'(rx_byte);
      else if (hit.rxstat) bus_rdata = DATA_W'(rx_held);
    end
  end

  assign ram_sel = hit.ram;
endmodule

// File: rtl/lmio_checker.sv
module lmio_checker #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] UART_BASE = '0,
  parameter logic [ADDR_W-1:0] RAM_BASE  = '0
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ram_sel,
  input logic [DATA_W-1:0] thread_pc,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready
);
  logic rd_zero, rd_pc, wr_tx, rd_rx;
  assign rd_zero = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == '0);
  assign rd_pc   = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign wr_tx   = bus_sel &&  bus_we && (bus_addr[ADDR_W-1:2] == UART_BASE[ADDR_W-1:2]);
  assign rd_rx   = bus_sel && !bus_we &&
                   (bus_addr[ADDR_W-1:2] == UART_BASE[ADDR_W-1:2] + (ADDR_W-2)'(2));

  assert_zero_word_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_zero |-> bus_rdata == '0);

  assert_pc_view_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_pc |-> bus_rdata == thread_pc);

  assert_tx_load_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_tx && !tx_valid) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_tx_drop_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_tx && tx_valid && !tx_ready) |=> $stable(tx_data));

  assert_rx_fill_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rx_valid && rx_ready) |=> !rx_ready);

  assert_rx_pop_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_rx && !rx_ready) |=> rx_ready);

  assert_ram_sel_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_sel && bus_addr >= RAM_BASE) |-> (ram_sel && bus_rdata == '0));

  assert_ram_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !bus_sel |-> !ram_sel);
endmodule

bind lowmem_io_decoder lmio_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BYTE_W    (BYTE_W),
  .UART_BASE (UART_BASE),
  .RAM_BASE  (RAM_BASE)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ram_sel    (ram_sel),
  .thread_pc  (thread_pc),
  .tx_data    (tx_data),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready)
);

// File: tb/lowmem_io_decoder_test.sv
module lowmem_io_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        ram_sel;
  logic [31:0] thread_pc, thread_psw;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [31:0] TXB = 32'h0800_0000;
  localparam logic [31:0] TXS = 32'h0800_0004;
  localparam logic [31:0] RXB = 32'h0800_0008;
  localparam logic [31:0] RXS = 32'h0800_000C;

  always #4 clk = ~clk;

  lowmem_io_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_sel(ram_sel), .thread_pc(thread_pc), .thread_psw(thread_psw),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  // Read: sample combinational data in the access cycle; the edge then commits
  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic rs);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata; rs = ram_sel;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic rs;
    check("R9 tx_valid", 32'(tx_valid), 32'd0);
    check("R9 rx_ready", 32'(rx_ready), 32'd1);
    rd(TXS, d, rs); check("R5 tx status empty", d, 32'd1);
    rd(RXS, d, rs); check("R6 rx status empty", d, 32'd0);
  endtask

  task automatic t_fixed();
    logic [31:0] d; logic rs;
    rd(32'h0, d, rs); check("R1 zero word", d, 32'h0);
    rd(32'h4, d, rs); check("R1 negative word", d, 32'h8000_0000);
    thread_pc = 32'h0000_0204; thread_psw = 32'h0000_0002;
    rd(32'h8, d, rs); check("R2 pc view", d, 32'h0000_0204);
    rd(32'hC, d, rs); check("R2 psw view", d, 32'h0000_0002);
    thread_pc = 32'hDEAD_BEE0; thread_psw = 32'h0000_0001;
    rd(32'h8, d, rs); check("R2 pc follows", d, 32'hDEAD_BEE0);
    rd(32'hC, d, rs); check("R2 psw follows", d, 32'h0000_0001);
  endtask

  task automatic t_fixed_writes();
    logic [31:0] d; logic rs;
    for (int i = 0; i < 4; i++) wr(32'(i * 4), 32'hFFFF_FFFF);
    rd(32'h0, d, rs); check("R3 zero after write", d, 32'h0);
    rd(32'h4, d, rs); check("R3 negative after write", d, 32'h8000_0000);
    rd(32'h8, d, rs); check("R3 pc after write", d, 32'hDEAD_BEE0);
    check("R3 no transmit", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_transmit();
    logic [31:0] d; logic rs;
    wr(TXB, 32'h1234_56A5);
    check("R4 tx_valid", 32'(tx_valid), 32'd1);
    check("R4 tx_data", 32'(tx_data), 32'hA5);
    rd(TXS, d, rs); check("R5 tx status full", d, 32'd0);
    wr(TXB, 32'h0000_0077);
    check("R5 dropped write", 32'(tx_data), 32'hA5);
    check("R4 still valid", 32'(tx_valid), 32'd1);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R4 drained", 32'(tx_valid), 32'd0);
    rd(TXS, d, rs); check("R5 tx status empty again", d, 32'd1);
    wr(TXB, 32'h0000_003C);
    check("R4 second byte", 32'(tx_data), 32'h3C);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_receive();
    logic [31:0] d; logic rs;
    rd(RXB, d, rs); check("R7 empty read", d, 32'd0);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5E;
    @(negedge clk); rx_valid = 1'b0;
    check("R6 rx_ready low when full", 32'(rx_ready), 32'd0);
    rd(RXS, d, rs); check("R6 rx status full", d, 32'd1);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h99;
    @(negedge clk); rx_valid = 1'b0;
    rd(RXB, d, rs); check("R7 byte returned", d, 32'h5E);
    check("R7 slot emptied", 32'(rx_ready), 32'd1);
    rd(RXS, d, rs); check("R7 status cleared", d, 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] d; logic rs;
    rd(32'h0800_0010, d, rs); check("R8 unmapped io", d, 32'd0);
    rd(32'h0000_0010, d, rs); check("R8 unmapped low", d, 32'd0);
    rd(32'h1FFF_FFFC, d, rs); check("R8 below ram sel", 32'(rs), 32'd0);
    rd(32'h2000_0000, d, rs);
    check("R8 ram base sel", 32'(rs), 32'd1);
    check("R8 ram base data", d, 32'd0);
    rd(32'hFFFF_FFFC, d, rs); check("R8 ram top sel", 32'(rs), 32'd1);
    #1 check("R8 idle no sel", 32'(ram_sel), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    thread_pc = '0; thread_psw = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fixed();
    t_fixed_writes();
    t_transmit();
    t_receive();
    t_map();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule